// File: doc/BRIEF.md
# Display Window Update Sequencer

This block pushes a rectangular region of pixel bytes to a grayscale display controller through a byte stream. Each byte in the stream is tagged as a command or as data, and a downstream serial engine consumes the stream. A request gives four coordinates: the first and last column and the first and last row. It also gives a frame-buffer base address and a row stride. The request is a single-cycle strobe and is only taken while the block is idle.

For an accepted request the block first sends a fixed preamble, which is one burst of seven bytes. The preamble opens the row window, then the column window, then arms the display's RAM write. After that the block reads pixel bytes from a frame-buffer read port and sends each row as its own burst. There are two bytes per column. Rows go in increasing order, and each new row starts one stride further on in the frame buffer.

A request that cannot be carried out is refused and raises an error pulse. This happens when either axis has its last coordinate below its first, or when a row would exceed the per-row byte limit. A refused request produces no output and no frame-buffer reads. The read port has a fixed latency given by a parameter, and it holds its data until the next read.

Top module: `window_update_seq`

## Requirements
- R1: The preamble is seven command-tagged or data-tagged beats in this order: the row command (`out_is_data`=0, value `CMD_SET_ROW`), then first row and last row (data), then the column command (`CMD_SET_COL`), then first column and last column (data), then the RAM-write command (`CMD_WRITE_RAM`). `out_last`=1 is set only on the RAM-write command.
- R2: Each row is one burst of 2×(last column − first column + 1) data beats. `out_last`=1 is set only on the final beat of each row. The burst after the preamble is the first row.
- R3: Row k (k = 0 for the first row) byte j comes from frame-buffer address (base + k×stride + j) modulo 2^ADDR_W. Rows are sent in increasing order up to and including the last row.
- R4: A request with last column < first column, or last row < first row, raises `err` for exactly the one cycle after the strobe. It sends no beat, issues no read and leaves `busy` low.
- R5: A request whose row would hold more than `MAX_ROW_BYTES` bytes is refused in the same way as R4. A request of exactly `MAX_ROW_BYTES` bytes per row is carried out.
- R6: A request is taken only while `busy` is low. A strobe while busy has no effect on the stream or on the job in progress. `busy` rises in the cycle after an accepted strobe.
- R7: `done` is high for exactly the one cycle after the final beat of the final row is accepted. `busy` falls in that same cycle.
- R8: While `out_valid` is high and `out_ready` is low, the beat is held stable and `out_valid` stays high.
- R9: After reset `out_valid`, `busy`, `done`, `err` and `fb_rd_en` are low. While `busy` is low, `out_valid` stays low.
- R10: `fb_rd_en` is high only while busy. Every command-tagged beat carries one of the three command parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe |
| col_first | input | COORD_W | First column of the window |
| col_last | input | COORD_W | Last column of the window |
| row_first | input | COORD_W | First row of the window |
| row_last | input | COORD_W | Last row of the window |
| fb_base | input | ADDR_W | Frame-buffer address of the first byte |
| fb_stride | input | ADDR_W | Address step between rows |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| fb_rd_en | output | 1 | Frame-buffer read enable |
| fb_rd_addr | output | ADDR_W | Frame-buffer read address |
| fb_rd_data | input | 8 | Frame-buffer read data, FB_LATENCY cycles after the read |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_is_data | output | 1 | 1 = data byte, 0 = command byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final beat of a burst |

## Verification
Several properties are checked by assertions on every cycle. These cover the idle-quiet rules, beat stability under backpressure, the legal command codes, and the RAM-write command being the only command that closes a burst. They also cover the single-cycle shape of `done` and `err`, and `done` following a closing data beat.

The exact byte order of the preamble, the byte count per row and the address arithmetic with stride and wraparound can only be shown by scenarios. The same holds for refusal of the three bad-request kinds, the boundary at exactly `MAX_ROW_BYTES`, and the ignored strobe during a job. For these, the bench compares every accepted beat against a queue built from the request.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_FETCH,
      ST_CAPT,
      ST_SEND
   } wseq_state_e;

   typedef struct packed {
      logic       is_data;
      logic [7:0] dat;
      logic       last;
   } wseq_beat_t;

   localparam int          PRE_BEATS = 7;
   localparam logic [2:0]  PRE_FINAL = 3'(PRE_BEATS - 1);

endpackage

// File: rtl/wseq_req_check.sv
module wseq_req_check #(
   parameter int COORD_W       = 8,
   parameter int MAX_ROW_BYTES = 128,
   parameter int BYTES_W       = 8
) (
   input  logic [COORD_W-1:0] c_first,
   input  logic [COORD_W-1:0] c_last,
   input  logic [COORD_W-1:0] r_first,
   input  logic [COORD_W-1:0] r_last,
   output logic               ok,
   output logic [BYTES_W-1:0] row_bytes
);
   localparam int FULL_W       = COORD_W + 2;
   localparam int LARGEST_ROW  = 2 * (1 << COORD_W);

   logic [COORD_W:0]  span;
   logic [FULL_W-1:0] bytes_full;
   logic              fits;

   assign span       = {1'b0, c_last} - {1'b0, c_first} + 1'b1;
   assign bytes_full = {span, 1'b0};

   generate
      if (MAX_ROW_BYTES >= LARGEST_ROW) begin : g_no_limit
         assign fits      = 1'b1;
         assign row_bytes = BYTES_W'(bytes_full);
      end else begin : g_limit
         assign fits      = (bytes_full <= FULL_W'(MAX_ROW_BYTES));
         assign row_bytes = bytes_full[BYTES_W-1:0];
         if (BYTES_W > FULL_W) begin : g_bad_w
            $error("byte counter wider than coordinate span");
         end
      end
   endgenerate

   assign ok = (c_last >= c_first) && (r_last >= r_first) && fits;

endmodule

// File: rtl/wseq_addr_gen.sv
module wseq_addr_gen #(
   parameter int ADDR_W  = 16,
   parameter int COORD_W = 8,
   parameter int BYTES_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  stride,
   input  logic [BYTES_W-1:0] row_bytes,
   input  logic [COORD_W-1:0] extra_rows,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr,
   output logic               end_of_row,
   output logic               end_of_rect
);
   logic [ADDR_W-1:0]  row_base;
   logic [ADDR_W-1:0]  stride_q;
   logic [BYTES_W-1:0] col_idx;
   logic [BYTES_W-1:0] nbytes;
   logic [COORD_W-1:0] rows_left;

   assign addr        = row_base + ADDR_W'(col_idx);
   assign end_of_row  = (col_idx == nbytes - BYTES_W'(1));
   assign end_of_rect = end_of_row && (rows_left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_base  <= '0;
         stride_q  <= '0;
         col_idx   <= '0;
         nbytes    <= '0;
         rows_left <= '0;
      end else if (load) begin
         row_base  <= base;
         stride_q  <= stride;
         col_idx   <= '0;
         nbytes    <= row_bytes;
         rows_left <= extra_rows;
      end else if (step) begin
         if (end_of_row) begin
            col_idx   <= '0;
            row_base  <= row_base + stride_q;
            rows_left <= rows_left - 1'b1;
         end else begin
            col_idx <= col_idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wseq_preamble.sv
module wseq_preamble
   import wseq_pkg::*;
#(
   parameter int         COORD_W       = 8,
   parameter logic [7:0] CMD_SET_ROW   = 8'h75,
   parameter logic [7:0] CMD_SET_COL   = 8'h15,
   parameter logic [7:0] CMD_WRITE_RAM = 8'h5C
) (
   input  logic [2:0]         idx,
   input  logic [COORD_W-1:0] c_first,
   input  logic [COORD_W-1:0] c_last,
   input  logic [COORD_W-1:0] r_first,
   input  logic [COORD_W-1:0] r_last,
   output wseq_beat_t         beat
);
   always_comb begin
      beat = '{is_data: 1'b0, dat: CMD_WRITE_RAM, last: 1'b1};
      case (idx)
         3'd0: beat = '{is_data: 1'b0, dat: CMD_SET_ROW, last: 1'b0};
         3'd1: beat = '{is_data: 1'b1, dat: 8'(r_first), last: 1'b0};
         3'd2: beat = '{is_data: 1'b1, dat: 8'(r_last), last: 1'b0};
         3'd3: beat = '{is_data: 1'b0, dat: CMD_SET_COL, last: 1'b0};
         3'd4: beat = '{is_data: 1'b1, dat: 8'(c_first), last: 1'b0};
         3'd5: beat = '{is_data: 1'b1, dat: 8'(c_last), last: 1'b0};
         default: ;
      endcase
   end

endmodule

// File: rtl/wseq_out_reg.sv
module wseq_out_reg
   import wseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  wseq_beat_t beat_in,
   input  logic       ready,
   output logic       valid,
   output wseq_beat_t beat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         beat  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         beat  <= beat_in;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/window_update_seq.sv
module window_update_seq
   import wseq_pkg::*;
#(
   parameter int         COORD_W       = 8,
   parameter int         ADDR_W        = 16,
   parameter int         MAX_ROW_BYTES = 128,
   parameter int         FB_LATENCY    = 1,
   parameter logic [7:0] CMD_SET_ROW   = 8'h75,
   parameter logic [7:0] CMD_SET_COL   = 8'h15,
   parameter logic [7:0] CMD_WRITE_RAM = 8'h5C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [COORD_W-1:0] col_first,
   input  logic [COORD_W-1:0] col_last,
   input  logic [COORD_W-1:0] row_first,
   input  logic [COORD_W-1:0] row_last,
   input  logic [ADDR_W-1:0]  fb_base,
   input  logic [ADDR_W-1:0]  fb_stride,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic               fb_rd_en,
   output logic [ADDR_W-1:0]  fb_rd_addr,
   input  logic [7:0]         fb_rd_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_is_data,
   output logic [7:0]         out_data,
   output logic               out_last
);
   localparam int BYTES_W = $clog2(MAX_ROW_BYTES + 1);
   localparam int CNT_W   = $clog2(FB_LATENCY + 1);

   generate
      if (COORD_W < 1 || COORD_W > 8) begin : g_bad_coord
         $error("COORD_W must lie in 1..8");
      end
      if (MAX_ROW_BYTES < 2) begin : g_bad_max
         $error("MAX_ROW_BYTES must be at least 2");
      end
      if (FB_LATENCY < 1) begin : g_bad_lat
         $error("FB_LATENCY must be at least 1");
      end
   endgenerate

   wseq_state_e        state;
   logic [2:0]         pre_idx;
   logic               in_row;
   logic               done_q;
   logic               err_q;
   logic [COORD_W-1:0] cf_q, cl_q, rf_q, rl_q;

   logic               req_ok;
   logic [BYTES_W-1:0] req_bytes;
   logic               accept;
   logic               ag_step;
   logic               eor, eorect;
   logic [ADDR_W-1:0]  ag_addr;
   logic               lat_hit;
   logic               hs;
   logic               ob_load;
   logic               ob_valid;
   wseq_beat_t         pre_beat, beat_in, beat_q;

   wseq_req_check #(
      .COORD_W(COORD_W), .MAX_ROW_BYTES(MAX_ROW_BYTES), .BYTES_W(BYTES_W)
   ) u_check (
      .c_first(col_first), .c_last(col_last),
      .r_first(row_first), .r_last(row_last),
      .ok(req_ok), .row_bytes(req_bytes)
   );

   assign accept  = (state == ST_IDLE) && req && req_ok;
   assign hs      = ob_valid && out_ready;
   assign ag_step = (state == ST_SEND) && hs && in_row;

   wseq_addr_gen #(
      .ADDR_W(ADDR_W), .COORD_W(COORD_W), .BYTES_W(BYTES_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n),
      .load(accept),
      .base(fb_base), .stride(fb_stride),
      .row_bytes(req_bytes),
      .extra_rows(row_last - row_first),
      .step(ag_step),
      .addr(ag_addr), .end_of_row(eor), .end_of_rect(eorect)
   );

   wseq_preamble #(
      .COORD_W(COORD_W), .CMD_SET_ROW(CMD_SET_ROW),
      .CMD_SET_COL(CMD_SET_COL), .CMD_WRITE_RAM(CMD_WRITE_RAM)
   ) u_pre (
      .idx(pre_idx),
      .c_first(cf_q), .c_last(cl_q), .r_first(rf_q), .r_last(rl_q),
      .beat(pre_beat)
   );

   generate
      if (FB_LATENCY == 1) begin : g_lat_one
         assign lat_hit = 1'b1;
      end else begin : g_lat_multi
         logic [CNT_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wait_cnt <= '0;
            else if (state == ST_FETCH)
               wait_cnt <= CNT_W'(1);
            else if (state == ST_CAPT && !lat_hit)
               wait_cnt <= wait_cnt + 1'b1;
         end
         assign lat_hit = (wait_cnt == CNT_W'(FB_LATENCY));
      end
   endgenerate

   always_comb begin
      ob_load = (state == ST_PRE) || ((state == ST_CAPT) && lat_hit);
      if (state == ST_PRE)
         beat_in = pre_beat;
      else
         beat_in = '{is_data: 1'b1, dat: fb_rd_data, last: eor};
   end

   wseq_out_reg u_out (
      .clk(clk), .rst_n(rst_n),
      .load(ob_load), .beat_in(beat_in), .ready(out_ready),
      .valid(ob_valid), .beat(beat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pre_idx <= '0;
         in_row  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         cf_q    <= '0;
         cl_q    <= '0;
         rf_q    <= '0;
         rl_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req) begin
                  if (req_ok) begin
                     cf_q    <= col_first;
                     cl_q    <= col_last;
                     rf_q    <= row_first;
                     rl_q    <= row_last;
                     pre_idx <= '0;
                     in_row  <= 1'b0;
                     state   <= ST_PRE;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_PRE:   state <= ST_SEND;
            ST_FETCH: state <= ST_CAPT;
            ST_CAPT:  if (lat_hit) state <= ST_SEND;
            ST_SEND: begin
               if (hs) begin
                  if (!in_row) begin
                     if (pre_idx == PRE_FINAL) begin
                        in_row <= 1'b1;
                        state  <= ST_FETCH;
                     end else begin
                        pre_idx <= pre_idx + 1'b1;
                        state   <= ST_PRE;
                     end
                  end else if (eorect) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_FETCH;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state != ST_IDLE);
   assign done        = done_q;
   assign err         = err_q;
   assign fb_rd_en    = (state == ST_FETCH);
   assign fb_rd_addr  = ag_addr;
   assign out_valid   = ob_valid;
   assign out_is_data = beat_q.is_data;
   assign out_data    = beat_q.dat;
   assign out_last    = beat_q.last;

endmodule

// File: rtl/wseq_checker.sv
module wseq_checker #(
   parameter logic [7:0] CMD_SET_ROW   = 8'h75,
   parameter logic [7:0] CMD_SET_COL   = 8'h15,
   parameter logic [7:0] CMD_WRITE_RAM = 8'h5C
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic       fb_rd_en,
   input logic       out_valid,
   input logic       out_ready,
   input logic       out_is_data,
   input logic [7:0] out_data,
   input logic       out_last
);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);

   p_rd_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fb_rd_en |-> busy);

   p_cmd_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is_data) |->
         (out_data == CMD_SET_ROW || out_data == CMD_SET_COL ||
          out_data == CMD_WRITE_RAM));

   p_last_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is_data && out_last) |-> (out_data == CMD_WRITE_RAM));

   p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable({out_is_data, out_data, out_last})));

   p_reject_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !out_valid && !fb_rd_en));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_done_follows_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid && out_ready && out_last && out_is_data));

endmodule

bind window_update_seq wseq_checker #(
   .CMD_SET_ROW(CMD_SET_ROW),
   .CMD_SET_COL(CMD_SET_COL),
   .CMD_WRITE_RAM(CMD_WRITE_RAM)
) u_wseq_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .fb_rd_en(fb_rd_en), .out_valid(out_valid), .out_ready(out_ready),
   .out_is_data(out_is_data), .out_data(out_data), .out_last(out_last)
);

// File: tb/tb_window_update_seq.sv
module tb_window_update_seq;
   localparam int         CLK_PERIOD = 10;
   localparam int         MAXB       = 128;
   localparam logic [7:0] C_ROW      = 8'h75;
   localparam logic [7:0] C_COL      = 8'h15;
   localparam logic [7:0] C_WR       = 8'h5C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [7:0]  col_first = '0, col_last = '0, row_first = '0, row_last = '0;
   logic [15:0] fb_base = '0, fb_stride = '0;
   logic        busy, done, err, fb_rd_en;
   logic [15:0] fb_rd_addr;
   logic [7:0]  fb_rd_data = '0;
   logic        out_valid, out_is_data, out_last;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;

   int total = 0;
   int bad = 0;
   int rdy_mode = 0;
   int rc = 0;
   int wd = 0;

   logic [9:0] exp_q[$];
   bit         model_busy = 0;
   bit         pend_done = 0;
   bit         pend_err = 0;
   bit         hold_pend = 0;
   logic [9:0] held;

   always #(CLK_PERIOD/2) clk = ~clk;

   window_update_seq dut (
      .clk(clk), .rst_n(rst_n), .req(req),
      .col_first(col_first), .col_last(col_last),
      .row_first(row_first), .row_last(row_last),
      .fb_base(fb_base), .fb_stride(fb_stride),
      .busy(busy), .done(done), .err(err),
      .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_is_data(out_is_data), .out_data(out_data), .out_last(out_last)
   );

   function automatic logic [7:0] fbv(input logic [15:0] a);
      logic [15:0] t;
      t = a * 16'd13 + 16'd7;
      return t[7:0] ^ a[15:8];
   endfunction

   always @(posedge clk) if (fb_rd_en) fb_rd_data <= fbv(fb_rd_addr);

   always @(posedge clk) begin
      rc++;
      #1;
      out_ready = (rdy_mode == 0) ? 1'b1 : ((rc % 3) != 2);
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_job(input int cf, input int cl, input int rf, input int rl,
                           input int base, input int stride);
      int nb;
      nb = 2 * (cl - cf + 1);
      exp_q.push_back({1'b0, C_ROW, 1'b0});
      exp_q.push_back({1'b1, 8'(rf), 1'b0});
      exp_q.push_back({1'b1, 8'(rl), 1'b0});
      exp_q.push_back({1'b0, C_COL, 1'b0});
      exp_q.push_back({1'b1, 8'(cf), 1'b0});
      exp_q.push_back({1'b1, 8'(cl), 1'b0});
      exp_q.push_back({1'b0, C_WR, 1'b1});
      for (int k = 0; k <= rl - rf; k++) begin
         for (int j = 0; j < nb; j++) begin
            logic [15:0] a;
            a = 16'(base + k * stride + j);
            exp_q.push_back({1'b1, fbv(a), (j == nb - 1)});
         end
      end
   endtask

   // reference model, evaluated once per clock on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [9:0] act;
         act = {out_is_data, out_data, out_last};
         chk(done == pend_done, "R7 done timing", done, pend_done);
         chk(err == pend_err, "R4/R5 err timing", err, pend_err);
         chk(busy == model_busy, "R6 busy state", busy, model_busy);
         pend_done = 0;
         pend_err  = 0;
         if (hold_pend)
            chk(out_valid && act == held, "R8 beat held", act, held);
         hold_pend = out_valid && !out_ready;
         held      = act;
         if (!model_busy) begin
            chk(!out_valid, "R9 idle valid", out_valid, 0);
            chk(!fb_rd_en, "R10 idle read", fb_rd_en, 0);
         end
         if (req && !model_busy) begin
            if (col_last < col_first || row_last < row_first ||
                2 * (int'(col_last) - int'(col_first) + 1) > MAXB)
               pend_err = 1;
            else begin
               push_job(col_first, col_last, row_first, row_last, fb_base, fb_stride);
               model_busy = 1;
            end
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
               chk(0, "R2 unexpected beat", act, 0);
            else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk(act == e, "R1/R2/R3 beat", act, e);
               if (exp_q.size() == 0) begin
                  pend_done  = 1;
                  model_busy = 0;
               end
            end
         end
      end
   end

   task automatic send(input int cf, input int cl, input int rf, input int rl,
                       input int base, input int stride);
      @(posedge clk); #1;
      col_first = 8'(cf); col_last = 8'(cl);
      row_first = 8'(rf); row_last = 8'(rl);
      fb_base = 16'(base); fb_stride = 16'(stride);
      req = 1'b1;
      @(posedge clk); #1;
      req = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      bit fin;
      fin = 0;
      for (int i = 0; i < 20000 && !fin; i++) begin
         @(negedge clk);
         if (!model_busy && exp_q.size() == 0) fin = 1;
      end
      if (!fin) chk(0, tag, exp_q.size(), 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!out_valid, "R9 reset valid", out_valid, 0);
      chk(!busy, "R9 reset busy", busy, 0);
      chk(!done, "R9 reset done", done, 0);
      chk(!err, "R9 reset err", err, 0);
      chk(!fb_rd_en, "R9 reset read", fb_rd_en, 0);

      // R1 R2 R3: three rows of six bytes, full throughput
      send(2, 4, 5, 7, 100, 40);
      wait_idle("R2 job1 hang");

      // R8: single column, backpressure
      rdy_mode = 1;
      send(0, 0, 3, 3, 16'h01F0, 10);
      wait_idle("R8 job2 hang");

      // R5 boundary: exactly 128 bytes per row accepted
      rdy_mode = 0;
      send(10, 73, 0, 1, 0, 200);
      wait_idle("R5 job3 hang");

      // R5: 130 bytes refused
      send(0, 64, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      // R4: columns reversed, then rows reversed
      send(5, 4, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      send(0, 1, 6, 2, 0, 0);
      repeat (3) @(negedge clk);

      // R6: strobe during a job is ignored
      send(1, 2, 0, 2, 500, 30);
      repeat (6) @(posedge clk);
      send(0, 0, 0, 0, 7, 7);
      wait_idle("R6 job4 hang");

      // R3: address wraparound with backpressure, back-to-back with next job
      rdy_mode = 1;
      send(0, 3, 0, 1, 16'hFFF0, 16'h0020);
      wait_idle("R3 job5 hang");
      send(7, 7, 9, 12, 16'h0300, 16'h0100);
      wait_idle("R3 job6 hang");

      chk(exp_q.size() == 0, "R2 leftover beats", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule